// File: doc/BRIEF.md
# Register Hazard Tracker With Forwarding Select

This block sits at the issue point of a single-issue, in-order integer pipeline. It keeps a small state machine per architectural register that records whether a write to that register is still in flight, and if so, whether the producing unit can hand its result straight to the next instruction. The one-cycle integer execute stage can forward. The load/store path cannot. For every source operand of the instruction waiting to issue, the tracker decides independently whether that operand must wait or can be taken from the execute result.

A wait on any operand holds the whole instruction through the combinational `stall` output. When an instruction issues, its per-operand forward selects are registered alongside a valid flag. That registered group travels with the instruction into execute and drives the three-way operand input multiplexer there. An entry is released when the writeback port reports a write to its register. Load and store instructions never take a forwarded operand, so they also wait on forwardable pending writes. Register index 0 can be exempted from hazard checks when it reads as a constant zero.

Each register slot has three named states. FREE means no write is pending. FWD means a pending write will come from the execute stage. WAIT means a pending write will come from the load/store path. The transitions are:

- FREE→FWD and FREE→WAIT, on issue of a writer, depending on its forward flag.
- FWD→FREE and WAIT→FREE, on a writeback to that register.
- FWD→WAIT, WAIT→FWD and self-loops, on a new issue to the same register. A new issue takes precedence over a writeback in the same cycle.

Top module: `hazard_bypass_tracker`

## Requirements
- R1: After reset every register slot is FREE, `stall` is 0 while `dec_valid` is 0, and `ex_valid` and `ex_fwd` are 0.
- R2: An issued writer with `dec_dst_fwd`=1 puts its register in FWD. A later reader of that register does not stall, and one cycle after it issues, its `ex_fwd` bit is 1. Bit k of `ex_fwd` belongs to source operand k.
- R3: A reader of a register in WAIT (writer had `dec_dst_fwd`=0) sees `stall`=1 in the same cycle, and keeps seeing it until a writeback to that register has been observed.
- R4: Each source operand is checked on its own. Only the operands whose register is in FWD get their `ex_fwd` bit set.
- R5: While `stall` is 1 the instruction does not issue. `ex_valid` is 0 in the next cycle, and its destination is not recorded.
- R6: With `ZERO_R0`=1, a source with index 0 never causes a stall or a forward, whatever the state of slot 0.
- R7: A consumer marked `dec_mem`=1 stalls on a source in FWD or WAIT, and always issues with `ex_fwd`=0.
- R8: A writeback frees the slot from the next cycle on. A writeback in the same cycle as an issue to the same register leaves the register pending, in the state chosen by the new writer.
- R9: `ex_valid` is 1 exactly one cycle after an issue (`dec_valid`=1, `stall`=0). When `ex_valid` is 0, `ex_fwd` is 0.
- R10: A source whose `dec_src_valid` bit is 0 never causes a stall or a forward.
- R11: With `dec_valid`=0, `stall` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Instruction waiting to issue |
| dec_src_valid | input | NSRC | Per-operand register-read flag |
| dec_src_idx | input | NSRC*IDXW | Source indices, operand k in bits k*IDXW +: IDXW |
| dec_mem | input | 1 | Consumer is a load/store (no forwarding allowed) |
| dec_dst_valid | input | 1 | Instruction writes a register |
| dec_dst_idx | input | IDXW | Destination index |
| dec_dst_fwd | input | 1 | Result comes from the execute stage (forwardable) |
| wb_valid | input | 1 | A register write completes |
| wb_idx | input | IDXW | Register written back |
| stall | output | 1 | Hold the waiting instruction |
| ex_valid | output | 1 | Registered: an instruction entered execute |
| ex_fwd | output | NSRC | Registered per-operand forward selects |

## Verification
`stall` is combinational. It is due in the same cycle as the inputs, so the bench drives inputs at the falling edge and samples `stall` a short time later, before the rising edge. `ex_valid` and `ex_fwd` pass through one register and are due just after the rising edge that ends the issue cycle. The bench samples them one time unit after that edge. A writeback changes slot state only at that same edge, so its effect on `stall` is checked on the following vector. Each table row covers exactly one clock cycle.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
    typedef enum logic [1:0] {
        SLOT_FREE = 2'd0,
        SLOT_FWD  = 2'd1,
        SLOT_WAIT = 2'd2
    } slot_state_e;
endpackage

// File: rtl/hzd_slot.sv
module hzd_slot
    import hzd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        set_en,
    input  logic        set_fwd,
    input  logic        clr_en,
    output slot_state_e state
);
    slot_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_FREE;
        else        state_q <= state_d;
    end

    // New writer wins over a writeback in the same cycle.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_FREE: begin
                if (set_en) state_d = set_fwd ? SLOT_FWD : SLOT_WAIT;
            end
            SLOT_FWD, SLOT_WAIT: begin
                if (set_en)      state_d = set_fwd ? SLOT_FWD : SLOT_WAIT;
                else if (clr_en) state_d = SLOT_FREE;
            end
            default: state_d = SLOT_FREE;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/hzd_operand_check.sv
module hzd_operand_check
    import hzd_pkg::*;
#(
    parameter int NREG    = 32,
    parameter int IDXW    = $clog2(NREG),
    parameter bit ZERO_R0 = 1'b1
) (
    input  logic                   src_valid,
    input  logic [IDXW-1:0]        src_idx,
    input  logic                   consumer_mem,
    input  slot_state_e [NREG-1:0] states,
    output logic                   need_stall,
    output logic                   use_fwd
);
    slot_state_e st;
    logic        exempt;
    logic        live;

    always_comb begin
        st         = states[src_idx];
        exempt     = ZERO_R0 && (src_idx == '0);
        live       = src_valid && !exempt;
        use_fwd    = live && (st == SLOT_FWD) && !consumer_mem;
        need_stall = live && ((st == SLOT_WAIT) || ((st == SLOT_FWD) && consumer_mem));
    end
endmodule

// File: rtl/hazard_bypass_tracker.sv
module hazard_bypass_tracker
    import hzd_pkg::*;
#(
    parameter int NREG    = 32,
    parameter int NSRC    = 3,
    parameter int IDXW    = $clog2(NREG),
    parameter bit ZERO_R0 = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dec_valid,
    input  logic [NSRC-1:0]      dec_src_valid,
    input  logic [NSRC*IDXW-1:0] dec_src_idx,
    input  logic                 dec_mem,
    input  logic                 dec_dst_valid,
    input  logic [IDXW-1:0]      dec_dst_idx,
    input  logic                 dec_dst_fwd,
    input  logic                 wb_valid,
    input  logic [IDXW-1:0]      wb_idx,
    output logic                 stall,
    output logic                 ex_valid,
    output logic [NSRC-1:0]      ex_fwd
);
    slot_state_e [NREG-1:0] slot_st;
    logic [NSRC-1:0] op_stall;
    logic [NSRC-1:0] op_fwd;
    logic            issue;

    for (genvar r = 0; r < NREG; r++) begin : g_slot
        hzd_slot u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_en  (issue && dec_dst_valid && (dec_dst_idx == IDXW'(r))),
            .set_fwd (dec_dst_fwd),
            .clr_en  (wb_valid && (wb_idx == IDXW'(r))),
            .state   (slot_st[r])
        );
    end

    for (genvar k = 0; k < NSRC; k++) begin : g_op
        hzd_operand_check #(
            .NREG    (NREG),
            .IDXW    (IDXW),
            .ZERO_R0 (ZERO_R0)
        ) u_chk (
            .src_valid    (dec_src_valid[k]),
            .src_idx      (dec_src_idx[k*IDXW +: IDXW]),
            .consumer_mem (dec_mem),
            .states       (slot_st),
            .need_stall   (op_stall[k]),
            .use_fwd      (op_fwd[k])
        );
    end

    assign stall = dec_valid && (|op_stall);
    assign issue = dec_valid && !stall;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ex_valid <= 1'b0;
            ex_fwd   <= '0;
        end else begin
            ex_valid <= issue;
            ex_fwd   <= issue ? op_fwd : '0;
        end
    end
endmodule

// File: rtl/hzd_checker.sv
module hzd_checker #(
    parameter int NSRC    = 3,
    parameter int IDXW    = 5,
    parameter bit ZERO_R0 = 1'b1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 dec_valid,
    input logic [NSRC*IDXW-1:0] dec_src_idx,
    input logic                 dec_mem,
    input logic                 stall,
    input logic                 ex_valid,
    input logic [NSRC-1:0]      ex_fwd
);
    // R5
    a_r5_stall_blocks_issue: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !ex_valid);
    // R9
    a_r9_issue_reaches_ex: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !stall) |=> ex_valid);
    a_r9_fwd_only_when_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_valid |-> (ex_fwd == '0));
    // R7
    a_r7_mem_no_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_mem && !stall) |=> (ex_fwd == '0));
    // R11
    a_r11_idle_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> !stall);
    // R6
    a_r6_zero_src_free: assert property (@(posedge clk) disable iff (!rst_n)
        (ZERO_R0 && dec_src_idx == '0) |-> !stall);
endmodule

bind hazard_bypass_tracker hzd_checker #(
    .NSRC    (NSRC),
    .IDXW    (IDXW),
    .ZERO_R0 (ZERO_R0)
) u_hzd_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .dec_valid   (dec_valid),
    .dec_src_idx (dec_src_idx),
    .dec_mem     (dec_mem),
    .stall       (stall),
    .ex_valid    (ex_valid),
    .ex_fwd      (ex_fwd)
);

// File: tb/test_hazard_bypass_tracker.sv
module test_hazard_bypass_tracker;
    localparam int NSRC = 3;
    localparam int IDXW = 5;

    typedef struct packed {
        logic [3:0] rq;
        logic       dv;
        logic [2:0] sv;
        logic [4:0] s0;
        logic [4:0] s1;
        logic [4:0] s2;
        logic       mem;
        logic       dstv;
        logic [4:0] dst;
        logic       dfwd;
        logic       wbv;
        logic [4:0] wb;
        logic       es;
        logic       ev;
        logic [2:0] ef;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{4'd2, 1'b1, 3'b000, 5'd0,  5'd0, 5'd0, 1'b0, 1'b1, 5'd5,  1'b1, 1'b0, 5'd0,  1'b0, 1'b1, 3'b000}, // R2 writer r5 fwd
        '{4'd2, 1'b1, 3'b001, 5'd5,  5'd0, 5'd0, 1'b0, 1'b0, 5'd0,  1'b0, 1'b0, 5'd0,  1'b0, 1'b1, 3'b001}, // R2 forward op0
        '{4'd3, 1'b1, 3'b000, 5'd0,  5'd0, 5'd0, 1'b0, 1'b1, 5'd6,  1'b0, 1'b0, 5'd0,  1'b0, 1'b1, 3'b000}, // R3 load writes r6
        '{4'd3, 1'b1, 3'b010, 5'd0,  5'd6, 5'd0, 1'b0, 1'b0, 5'd0,  1'b0, 1'b0, 5'd0,  1'b1, 1'b0, 3'b000}, // R3 stall
        '{4'd3, 1'b1, 3'b010, 5'd0,  5'd6, 5'd0, 1'b0, 1'b0, 5'd0,  1'b0, 1'b0, 5'd0,  1'b1, 1'b0, 3'b000}, // R3 still
        '{4'd8, 1'b1, 3'b010, 5'd0,  5'd6, 5'd0, 1'b0, 1'b0, 5'd0,  1'b0, 1'b1, 5'd6,  1'b1, 1'b0, 3'b000}, // R8 wb this cycle
        '{4'd8, 1'b1, 3'b010, 5'd0,  5'd6, 5'd0, 1'b0, 1'b0, 5'd0,  1'b0, 1'b0, 5'd0,  1'b0, 1'b1, 3'b000}, // R8 freed
        '{4'd4, 1'b1, 3'b111, 5'd5,  5'd7, 5'd5, 1'b0, 1'b0, 5'd0,  1'b0, 1'b0, 5'd0,  1'b0, 1'b1, 3'b101}, // R4 mixed
        '{4'd7, 1'b1, 3'b100, 5'd0,  5'd0, 5'd5, 1'b1, 1'b0, 5'd0,  1'b0, 1'b0, 5'd0,  1'b1, 1'b0, 3'b000}, // R7 mem stalls
        '{4'd11,1'b0, 3'b000, 5'd0,  5'd0, 5'd0, 1'b0, 1'b0, 5'd0,  1'b0, 1'b1, 5'd5,  1'b0, 1'b0, 3'b000}, // R11 idle, wb r5
        '{4'd7, 1'b1, 3'b001, 5'd5,  5'd0, 5'd0, 1'b1, 1'b0, 5'd0,  1'b0, 1'b0, 5'd0,  1'b0, 1'b1, 3'b000}, // R7 free mem read
        '{4'd6, 1'b1, 3'b000, 5'd0,  5'd0, 5'd0, 1'b0, 1'b1, 5'd0,  1'b0, 1'b0, 5'd0,  1'b0, 1'b1, 3'b000}, // R6 load to r0
        '{4'd6, 1'b1, 3'b111, 5'd0,  5'd0, 5'd0, 1'b0, 1'b0, 5'd0,  1'b0, 1'b0, 5'd0,  1'b0, 1'b1, 3'b000}, // R6 r0 exempt
        '{4'd10,1'b1, 3'b000, 5'd0,  5'd0, 5'd0, 1'b0, 1'b1, 5'd9,  1'b0, 1'b0, 5'd0,  1'b0, 1'b1, 3'b000}, // R10 load r9
        '{4'd10,1'b1, 3'b000, 5'd9,  5'd0, 5'd0, 1'b0, 1'b0, 5'd0,  1'b0, 1'b0, 5'd0,  1'b0, 1'b1, 3'b000}, // R10 unread op
        '{4'd5, 1'b1, 3'b001, 5'd9,  5'd0, 5'd0, 1'b0, 1'b1, 5'd10, 1'b1, 1'b0, 5'd0,  1'b1, 1'b0, 3'b000}, // R5 stalled writer
        '{4'd11,1'b0, 3'b000, 5'd0,  5'd0, 5'd0, 1'b0, 1'b0, 5'd0,  1'b0, 1'b1, 5'd9,  1'b0, 1'b0, 3'b000}, // R11 wb r9
        '{4'd5, 1'b1, 3'b001, 5'd10, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0,  1'b0, 1'b0, 5'd0,  1'b0, 1'b1, 3'b000}, // R5 r10 unrecorded
        '{4'd2, 1'b1, 3'b000, 5'd0,  5'd0, 5'd0, 1'b0, 1'b1, 5'd11, 1'b1, 1'b0, 5'd0,  1'b0, 1'b1, 3'b000}, // R2 r11 fwd
        '{4'd8, 1'b1, 3'b000, 5'd0,  5'd0, 5'd0, 1'b0, 1'b1, 5'd11, 1'b0, 1'b1, 5'd11, 1'b0, 1'b1, 3'b000}, // R8 issue beats wb
        '{4'd8, 1'b1, 3'b001, 5'd11, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0,  1'b0, 1'b0, 5'd0,  1'b1, 1'b0, 3'b000}, // R8 now WAIT
        '{4'd11,1'b0, 3'b001, 5'd11, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0,  1'b0, 1'b1, 5'd11, 1'b0, 1'b0, 3'b000}, // R11 idle on hazard
        '{4'd9, 1'b1, 3'b001, 5'd11, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0,  1'b0, 1'b0, 5'd0,  1'b0, 1'b1, 3'b000}  // R9 issue
    };

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic                 dec_valid;
    logic [NSRC-1:0]      dec_src_valid;
    logic [NSRC*IDXW-1:0] dec_src_idx;
    logic                 dec_mem;
    logic                 dec_dst_valid;
    logic [IDXW-1:0]      dec_dst_idx;
    logic                 dec_dst_fwd;
    logic                 wb_valid;
    logic [IDXW-1:0]      wb_idx;
    logic                 stall;
    logic                 ex_valid;
    logic [NSRC-1:0]      ex_fwd;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    hazard_bypass_tracker i_hazard_bypass_tracker (
        .clk (clk), .rst_n (rst_n), .dec_valid (dec_valid),
        .dec_src_valid (dec_src_valid), .dec_src_idx (dec_src_idx),
        .dec_mem (dec_mem), .dec_dst_valid (dec_dst_valid),
        .dec_dst_idx (dec_dst_idx), .dec_dst_fwd (dec_dst_fwd),
        .wb_valid (wb_valid), .wb_idx (wb_idx), .stall (stall),
        .ex_valid (ex_valid), .ex_fwd (ex_fwd)
    );

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive_idle();
        dec_valid = 0; dec_src_valid = '0; dec_src_idx = '0; dec_mem = 0;
        dec_dst_valid = 0; dec_dst_idx = '0; dec_dst_fwd = 0; wb_valid = 0; wb_idx = '0;
    endtask

    task automatic apply(input vec_t v);
        dec_valid = v.dv; dec_src_valid = v.sv; dec_src_idx = {v.s2, v.s1, v.s0};
        dec_mem = v.mem; dec_dst_valid = v.dstv; dec_dst_idx = v.dst; dec_dst_fwd = v.dfwd;
        wb_valid = v.wbv; wb_idx = v.wb;
    endtask

    initial begin
        rst_n = 0;
        drive_idle();
        repeat (3) @(negedge clk);
        #2;
        chk("R1", "stall in reset", {7'd0, stall}, 8'd0);
        chk("R1", "ex_valid in reset", {7'd0, ex_valid}, 8'd0);
        chk("R1", "ex_fwd in reset", {5'd0, ex_fwd}, 8'd0);
        @(negedge clk);
        rst_n = 1;

        for (int i = 0; i < NV; i++) begin
            string rq;
            rq = $sformatf("R%0d(v%0d)", VECS[i].rq, i);
            apply(VECS[i]);
            #2;
            chk(rq, "stall", {7'd0, stall}, {7'd0, VECS[i].es});
            @(posedge clk);
            #1;
            chk(rq, "ex_valid", {7'd0, ex_valid}, {7'd0, VECS[i].ev});
            chk(rq, "ex_fwd", {5'd0, ex_fwd}, {5'd0, VECS[i].ef});
            @(negedge clk);
        end

        // R1: reset clears a pending load write to r12
        apply('{4'd1, 1'b1, 3'b000, 5'd0, 5'd0, 5'd0, 1'b0, 1'b1, 5'd12, 1'b0, 1'b0, 5'd0, 1'b0, 1'b1, 3'b000});
        @(negedge clk);
        drive_idle();
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        apply('{4'd1, 1'b1, 3'b001, 5'd12, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b1, 3'b000});
        #2;
        chk("R1", "stall after reset on r12", {7'd0, stall}, 8'd0);
        @(posedge clk);
        #1;
        chk("R1", "ex_valid after reset", {7'd0, ex_valid}, 8'd1);
        @(negedge clk);
        drive_idle();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule